// File: doc/BRIEF.md
# Stack and Subroutine Sequencer

This block is the multi-cycle control unit that runs the stack and control-transfer instructions of an 8-bit accumulator machine with a 256-byte memory. It owns the program counter and the stack pointer. It drives one single-port synchronous memory port with an address, write data, a write enable and read data that arrives one clock after the address. A fetch stage hands it one instruction at a time: an opcode, the operand byte for two-byte instructions, and the current accumulator value. It then raises a one-cycle done pulse when the instruction has finished.

The stack grows downward. A push decrements first and then stores. A pop loads first and then increments. A subroutine call stores the address just past its own two bytes, and a return loads that address straight into the PC. The block also handles the two stack-pointer loads, halt, and the PC step for every other legal opcode. It does not compute any ALU results and does not perform any I/O. An opcode above 49h stops the machine and marks it illegal.

Top module: `stack_seq`

## Requirements
- R1: After a synchronous active-low reset, pc and sp are 00h, busy, done, halted and illegal are low, and mem_we is low.
- R2: Push (opcode 10h) decrements sp by one, writes acc_in to memory at the new sp, and advances pc by 1.
- R3: Pop (opcode 11h) reads memory at sp and presents the value on acc_out with acc_load high during the done cycle. In that cycle flag_n equals bit 7 of the value, flag_z is high only for zero, and flag_v_clr is high. After the pop, sp is incremented by one and pc is advanced by 1.
- R4: Return (opcode 12h) loads pc from memory at sp and then increments sp.
- R5: Call (opcode 49h) decrements sp, writes pc+2 to memory at the new sp, and sets pc to the operand.
- R6: Stack-pointer load from memory (opcode 1Fh) sets sp to the memory byte at the operand address and advances pc by 2.
- R7: Stack-pointer load immediate (opcode 20h) sets sp to the operand, advances pc by 2, and performs no memory write.
- R8: Every other opcode from 00h to 1Bh advances pc by 1, and every other opcode from 1Ch to 48h advances pc by 2. Neither case changes sp or writes memory.
- R9: Halt (opcode 01h) advances pc by 1 and sets halted. While halted, issue is ignored: no done pulse, no pc, sp or memory change.
- R10: An opcode above 49h leaves pc unchanged, sets both halted and illegal, and raises done.
- R11: pc and sp wrap modulo 256. For example, a push with sp at 00h writes address FFh.
- R12: done is a single-cycle pulse. It arrives in the third clock after the issue edge for push, pop, return, call and stack-pointer load from memory, and in the first clock for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Start an instruction (taken only when idle and not halted) |
| opcode | input | 8 | Instruction opcode |
| operand | input | 8 | Second instruction byte |
| acc_in | input | 8 | Accumulator value, used by push |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, one clock after the address |
| pc | output | 8 | Program counter |
| sp | output | 8 | Stack pointer |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Instruction complete pulse |
| halted | output | 1 | Fetch stopped |
| illegal | output | 1 | Halted on an undefined opcode |
| acc_load | output | 1 | acc_out must be written to the accumulator |
| acc_out | output | 8 | Popped value |
| flag_n | output | 1 | Negative flag for the popped value |
| flag_z | output | 1 | Zero flag for the popped value |
| flag_v_clr | output | 1 | Clear the overflow flag |

## Verification
The assertions assume that issue is offered only while the block is idle, or is simply ignored otherwise. They also assume that mem_rdata comes from a memory that returns the byte addressed in the previous clock. The bench meets both assumptions with a registered 256-byte model. It raises issue for exactly one clock and then waits for done before it offers the next instruction. Random opcodes are drawn only from the legal stack, step and branch codes, with random operands, accumulator values and memory contents. Halt and illegal codes appear only in directed sequences that end with a reset.

// File: rtl/ssq_pkg.sv
// Package for the stack sequencer: opcode values, the instruction class
// and the control state encoding. Assumes 8-bit opcodes.
package ssq_pkg;

    localparam logic [7:0] OP_HALT      = 8'h01;
    localparam logic [7:0] OP_PUSH      = 8'h10;
    localparam logic [7:0] OP_POP       = 8'h11;
    localparam logic [7:0] OP_RET       = 8'h12;
    localparam logic [7:0] OP_SP_MEM    = 8'h1F;
    localparam logic [7:0] OP_SP_IMM    = 8'h20;
    localparam logic [7:0] OP_CALL      = 8'h49;
    localparam logic [7:0] OP_LAST_1B   = 8'h1B;
    localparam logic [7:0] OP_LAST_OK   = 8'h49;

    typedef enum logic [3:0] {
        K_STEP, K_HALT, K_BAD, K_PUSH, K_POP, K_RET, K_CALL, K_SPMEM, K_SPIMM
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEC, ST_WRITE, ST_READ, ST_LATCH, ST_FIN
    } state_e;

    // Map an opcode to its execution class.
    function automatic kind_e classify(input logic [7:0] op);
        kind_e k;
        if (op > OP_LAST_OK) k = K_BAD;
        else begin
            case (op)
                OP_HALT:   k = K_HALT;
                OP_PUSH:   k = K_PUSH;
                OP_POP:    k = K_POP;
                OP_RET:    k = K_RET;
                OP_CALL:   k = K_CALL;
                OP_SP_MEM: k = K_SPMEM;
                OP_SP_IMM: k = K_SPIMM;
                default:   k = K_STEP;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/ssq_decode.sv
// Opcode decoder: gives the instruction class and whether the instruction
// carries an operand byte. Purely combinational.
module ssq_decode
    import ssq_pkg::*;
(
    input  logic [7:0] op_i,
    output kind_e      kind_o,
    output logic       two_byte_o
);
    // Classify the opcode and derive its length.
    always_comb begin
        kind_o     = classify(op_i);
        two_byte_o = (op_i > OP_LAST_1B);
    end
endmodule

// File: rtl/ssq_ctrl.sv
// Control state machine: accepts an instruction when idle and not halted,
// captures its class, length and operand, and steps through the memory
// phases. Assumes the memory returns read data one clock after the address.
module ssq_ctrl
    import ssq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue_i,
    input  kind_e        kind_i,
    input  logic         two_byte_i,
    input  logic [W-1:0] arg_i,
    output logic         accept_o,
    output state_e       state_o,
    output kind_e        kind_o,
    output logic         two_byte_o,
    output logic [W-1:0] arg_o,
    output logic         halted_o,
    output logic         illegal_o
);
    state_e state_q, state_d;

    assign accept_o = issue_i && (state_q == ST_IDLE) && !halted_o;
    assign state_o  = state_q;

    // Choose the next phase from the current phase and the instruction class.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (accept_o) begin
                case (kind_i)
                    K_PUSH, K_CALL:         state_d = ST_DEC;
                    K_POP, K_RET, K_SPMEM:  state_d = ST_READ;
                    default:                state_d = ST_FIN;
                endcase
            end
            ST_DEC:   state_d = ST_WRITE;
            ST_WRITE: state_d = ST_FIN;
            ST_READ:  state_d = ST_LATCH;
            ST_LATCH: state_d = ST_FIN;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Register the phase, the captured instruction and the stop flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            kind_o     <= K_STEP;
            two_byte_o <= 1'b0;
            arg_o      <= '0;
            halted_o   <= 1'b0;
            illegal_o  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                kind_o     <= kind_i;
                two_byte_o <= two_byte_i;
                arg_o      <= arg_i;
            end
            if (state_q == ST_FIN && (kind_o == K_HALT || kind_o == K_BAD))
                halted_o <= 1'b1;
            if (state_q == ST_FIN && kind_o == K_BAD)
                illegal_o <= 1'b1;
        end
    end
endmodule

// File: rtl/ssq_datapath.sv
// Datapath: program counter, stack pointer and accumulator holding register,
// plus the memory port drive. Acts on the phase and class given by the
// control unit; all arithmetic wraps modulo 2**W.
module ssq_datapath
    import ssq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept_i,
    input  state_e       state_i,
    input  kind_e        kind_i,
    input  logic         two_byte_i,
    input  logic [W-1:0] arg_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] rdata_i,
    output logic [W-1:0] addr_o,
    output logic [W-1:0] wdata_o,
    output logic         we_o,
    output logic [W-1:0] pc_o,
    output logic [W-1:0] sp_o,
    output logic [W-1:0] acc_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TWO = ONE << 1;

    logic [W-1:0] step_len;

    assign step_len = two_byte_i ? TWO : ONE;

    // Drive the memory port for the current phase.
    always_comb begin
        we_o    = (state_i == ST_WRITE);
        wdata_o = (kind_i == K_CALL) ? (pc_o + TWO) : acc_o;
        addr_o  = (state_i == ST_READ && kind_i == K_SPMEM) ? arg_i : sp_o;
    end

    // Update the PC, SP and accumulator copy phase by phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_o  <= '0;
            sp_o  <= '0;
            acc_o <= '0;
        end else begin
            if (accept_i) acc_o <= acc_i;
            case (state_i)
                ST_DEC: sp_o <= sp_o - ONE;
                ST_LATCH: begin
                    case (kind_i)
                        K_POP: begin
                            acc_o <= rdata_i;
                            sp_o  <= sp_o + ONE;
                        end
                        K_RET: begin
                            pc_o <= rdata_i;
                            sp_o <= sp_o + ONE;
                        end
                        K_SPMEM: sp_o <= rdata_i;
                        default: ;
                    endcase
                end
                ST_FIN: begin
                    case (kind_i)
                        K_CALL:  pc_o <= arg_i;
                        K_RET, K_BAD: ;
                        K_SPIMM: begin
                            sp_o <= arg_i;
                            pc_o <= pc_o + step_len;
                        end
                        default: pc_o <= pc_o + step_len;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stack_seq.sv
// Top of the stack and subroutine sequencer. Joins the decoder, the control
// unit and the datapath, and forms the completion and pop result outputs.
// Assumes issue is offered by a fetch stage that waits for done.
module stack_seq
    import ssq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         issue,
    input  logic [7:0]   opcode,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] acc_in,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         mem_we,
    input  logic [W-1:0] mem_rdata,
    output logic [W-1:0] pc,
    output logic [W-1:0] sp,
    output logic         busy,
    output logic         done,
    output logic         halted,
    output logic         illegal,
    output logic         acc_load,
    output logic [W-1:0] acc_out,
    output logic         flag_n,
    output logic         flag_z,
    output logic         flag_v_clr
);
    kind_e        dec_kind, cur_kind;
    logic         dec_two, cur_two, accept;
    logic [W-1:0] cur_arg;
    state_e       state;

    ssq_decode u_dec (
        .op_i       (opcode),
        .kind_o     (dec_kind),
        .two_byte_o (dec_two)
    );

    ssq_ctrl #(.W(W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .issue_i    (issue),
        .kind_i     (dec_kind),
        .two_byte_i (dec_two),
        .arg_i      (operand),
        .accept_o   (accept),
        .state_o    (state),
        .kind_o     (cur_kind),
        .two_byte_o (cur_two),
        .arg_o      (cur_arg),
        .halted_o   (halted),
        .illegal_o  (illegal)
    );

    ssq_datapath #(.W(W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .state_i    (state),
        .kind_i     (cur_kind),
        .two_byte_i (cur_two),
        .arg_i      (cur_arg),
        .acc_i      (acc_in),
        .rdata_i    (mem_rdata),
        .addr_o     (mem_addr),
        .wdata_o    (mem_wdata),
        .we_o       (mem_we),
        .pc_o       (pc),
        .sp_o       (sp),
        .acc_o      (acc_out)
    );

    // Form status and pop result outputs from the phase and class.
    always_comb begin
        busy       = (state != ST_IDLE);
        done       = (state == ST_FIN);
        acc_load   = done && (cur_kind == K_POP);
        flag_n     = acc_out[W-1];
        flag_z     = (acc_out == '0);
        flag_v_clr = acc_load;
    end
endmodule

// File: rtl/ssq_checker.sv
// Property checker for the stack sequencer, attached by bind. Assumes a
// memory with one-clock read latency and a fetch stage that waits for done.
module ssq_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         issue,
    input logic         busy,
    input logic         done,
    input logic         halted,
    input logic         illegal,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic [W-1:0] sp
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_write_predec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sp == $past(sp) - ONE) && (mem_addr == sp));

    p_write_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we);

    p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_halt_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !busy && issue) |=> !busy);

    p_illegal_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted);
endmodule

bind stack_seq ssq_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .issue    (issue),
    .busy     (busy),
    .done     (done),
    .halted   (halted),
    .illegal  (illegal),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .sp       (sp)
);

// File: tb/stack_seq_tb_top.sv
module stack_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       issue = 1'b0;
    logic [7:0] opcode = 8'h00, operand = 8'h00, acc_in = 8'h00;
    logic [7:0] mem_addr, mem_wdata, mem_rdata, pc, sp, acc_out;
    logic       mem_we, busy, done, halted, illegal, acc_load;
    logic       flag_n, flag_z, flag_v_clr;

    logic [7:0] ram [256];
    logic [7:0] ref_mem [256];
    logic [7:0] r_pc, r_sp, r_acc;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stack_seq dut_i (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .operand(operand), .acc_in(acc_in), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .pc(pc), .sp(sp), .busy(busy), .done(done), .halted(halted),
        .illegal(illegal), .acc_load(acc_load), .acc_out(acc_out),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v_clr(flag_v_clr)
    );

    // Registered single-port memory model.
    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int exp_cycles(input logic [7:0] op);
        return (op == 8'h10 || op == 8'h11 || op == 8'h12 ||
                op == 8'h49 || op == 8'h1F) ? 3 : 1;
    endfunction

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h10: return "R2";
            8'h11: return "R3";
            8'h12: return "R4";
            8'h49: return "R5";
            8'h1F: return "R6";
            8'h20: return "R7";
            8'h01: return "R9";
            default: return (op > 8'h49) ? "R10" : "R8";
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; issue = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        r_pc = 8'h00; r_sp = 8'h00;
    endtask

    // Issue one instruction, update the reference model, check the result.
    task automatic run_op(input logic [7:0] op, input logic [7:0] arg,
                          input logic [7:0] a);
        int n;
        logic [7:0] waddr;
        logic       wrote;
        string t;
        t = tag_of(op);
        wrote = 1'b0; waddr = 8'h00;
        case (op)
            8'h10: begin r_sp = r_sp - 1; ref_mem[r_sp] = a;
                         waddr = r_sp; wrote = 1'b1; r_pc = r_pc + 1; end
            8'h11: begin r_acc = ref_mem[r_sp]; r_sp = r_sp + 1; r_pc = r_pc + 1; end
            8'h12: begin r_pc = ref_mem[r_sp]; r_sp = r_sp + 1; end
            8'h49: begin r_sp = r_sp - 1; ref_mem[r_sp] = r_pc + 2;
                         waddr = r_sp; wrote = 1'b1; r_pc = arg; end
            8'h1F: begin r_sp = ref_mem[arg]; r_pc = r_pc + 2; end
            8'h20: begin r_sp = arg; r_pc = r_pc + 2; end
            default: if (op <= 8'h49) r_pc = r_pc + ((op > 8'h1B) ? 8'd2 : 8'd1);
        endcase
        @(negedge clk);
        issue = 1'b1; opcode = op; operand = arg; acc_in = a;
        @(negedge clk);
        issue = 1'b0;
        n = 1;
        while (!done && n < 10) begin @(negedge clk); n++; end
        chk({t, " R12 done cycle"}, n, exp_cycles(op));
        if (op == 8'h11) begin
            chk("R3 acc_load", acc_load, 1);
            chk("R3 acc_out", acc_out, r_acc);
            chk("R3 flag_n", flag_n, r_acc[7]);
            chk("R3 flag_z", flag_z, r_acc == 8'h00);
            chk("R3 flag_v_clr", flag_v_clr, 1);
        end
        @(negedge clk);
        chk({t, " pc"}, pc, r_pc);
        chk({t, " sp"}, sp, r_sp);
        chk({t, " done single R12"}, done, 0);
        if (wrote) chk({t, " memory write"}, ram[waddr], ref_mem[waddr]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [11];
        logic [7:0] keep;
        void'($urandom(32'h5EED_0042));
        ops = '{8'h10, 8'h11, 8'h12, 8'h49, 8'h1F, 8'h20,
                8'h00, 8'h05, 8'h1C, 8'h23, 8'h38};
        for (int i = 0; i < 256; i++) begin
            ram[i] = 8'($urandom);
            ref_mem[i] = ram[i];
        end
        r_acc = 8'h00;
        do_reset();
        // R1 reset state
        chk("R1 pc", pc, 0);
        chk("R1 sp", sp, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 halted", halted, 0);
        chk("R1 illegal", illegal, 0);
        chk("R1 mem_we", mem_we, 0);

        // R11 wrap: push at sp 00h lands at FFh, pop returns; pc wraps.
        run_op(8'h10, 8'h00, 8'h80);
        chk("R11 sp wrap", sp, 8'hFF);
        run_op(8'h11, 8'h00, 8'h00);
        chk("R11 sp back", sp, 8'h00);
        run_op(8'h10, 8'h00, 8'h00);
        run_op(8'h11, 8'h00, 8'h33);
        run_op(8'h49, 8'hFF, 8'h00);
        run_op(8'h00, 8'h00, 8'h00);
        chk("R11 pc wrap", pc, 8'h00);
        run_op(8'h12, 8'h00, 8'h00);
        run_op(8'h20, 8'h40, 8'h00);
        run_op(8'h1F, 8'h41, 8'h00);

        // Random mix of legal opcodes.
        for (int i = 0; i < 300; i++) begin
            run_op(ops[$urandom_range(10, 0)], 8'($urandom), 8'($urandom));
        end

        // R9 halt, then ignored issue.
        run_op(8'h01, 8'h00, 8'h00);
        chk("R9 halted", halted, 1);
        keep = ram[8'(r_sp - 1)];
        @(negedge clk);
        issue = 1'b1; opcode = 8'h10; acc_in = ~keep;
        @(negedge clk);
        issue = 1'b0;
        begin
            int seen = 0;
            for (int k = 0; k < 5; k++) begin
                if (done || busy) seen++;
                @(negedge clk);
            end
            chk("R9 no activity", seen, 0);
        end
        chk("R9 pc hold", pc, r_pc);
        chk("R9 sp hold", sp, r_sp);
        chk("R9 memory untouched", ram[8'(r_sp - 1)], keep);

        // R10 illegal opcode.
        do_reset();
        run_op(8'h20, 8'h10, 8'h00);
        run_op(8'h9A, 8'h00, 8'h00);
        chk("R10 halted", halted, 1);
        chk("R10 illegal", illegal, 1);
        do_reset();
        chk("R1 illegal cleared", illegal, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule